// File: doc/BRIEF.md
# Raster to 10-bit tile packer

This block takes one plane of 10-bit raster video, one sample per accepted beat, and rewrites it as tiles three samples wide and four rows tall. Every tile leaves as one 128-bit word: the twelve samples fill the low 120 bits, and eight zero bits fill the top. Tiles go out left to right across each band of four rows. Every sixteen tiles make a 48x4 group of 256 bytes, and the first tile of each group is flagged.

The input is a valid/ready stream. A start-of-frame marker sits on the first sample of a frame and an end-of-line marker on the last sample of each line. Four lines are collected in internal storage. Once the fourth line of a band is complete, the band is drained through a valid/ready output. Each output word carries its tile index within the band. Input is stalled while a band drains. Frames whose line width is not a multiple of 48, changes between lines, or exceeds the storage raise an error and are discarded up to the next start-of-frame. A frame that ends partway through a band raises the same error.

Top module: `raster_tile_packer`

## Requirements
- R1: After a synchronous active-high reset, out_valid and err are 0 and in_ready is 1.
- R2: Tile word layout: the sample at tile row r (0..3, top first) and column c (0..2, left first) sits at bits [10*(3r+c)+9 : 10*(3r+c)], and bits [127:120] are zero.
- R3: Tiles of a band appear only after the last sample of the band's fourth line is accepted. Their out_tile values run 0, 1, ... up to width/3-1, with tile t covering sample columns 3t..3t+2.
- R4: out_gstart is 1 exactly on tiles whose index is a multiple of 16.
- R5: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_tile hold their values, and no tile is lost or repeated.
- R6: in_ready is 0 while a band is being emitted and returns to 1 once its last tile is taken.
- R7: If a line's length is not a multiple of 48, differs from the frame's first line, or exceeds MAX_W, err is set in the cycle after that line's end-of-line sample is accepted. No tile of that frame is emitted afterwards.
- R8: If a start-of-frame sample is accepted while a band is only partly filled, err is set, the partial rows are discarded, and the new frame starts normally.
- R9: Samples before the first start-of-frame are ignored. A start-of-frame that starts a frame with no pending error clears err.
- R10: A frame several bands tall yields its bands in top-to-bottom order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 10 | Sample value |
| in_sof | input | 1 | First sample of a frame |
| in_eol | input | 1 | Last sample of a line |
| out_valid | output | 1 | Tile word valid |
| out_ready | input | 1 | Consumer takes the tile word |
| out_data | output | 128 | Packed tile |
| out_tile | output | 10 | Tile index within the band |
| out_gstart | output | 1 | First tile of a 16-tile group |
| err | output | 1 | Sticky format error flag |

## Verification
The fourth end-of-line sample of a band is registered at a clock edge. The first tile is therefore valid during the next clock low phase, and the bench checks out_valid there, after it has confirmed that the flag was low before that edge. A tile is taken at the edge where out_valid and out_ready are both high, and the next tile is visible by the following falling edge. The bench drives and samples only on falling edges, so each tile is compared in the same half cycle in which it is handed over. err is registered together with the sample that causes it, so the bench reads err at the first falling edge after that sample is accepted.

// File: rtl/raster_tile_packer.sv
module raster_tile_packer #(
  parameter int SW    = 10,
  parameter int MAX_W = 1920
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [SW-1:0]                  in_data,
  input  logic                           in_sof,
  input  logic                           in_eol,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [127:0]                   out_data,
  output logic [$clog2(MAX_W/3)-1:0]     out_tile,
  output logic                           out_gstart,
  output logic                           err
);
  localparam int TILES = MAX_W / 3;
  localparam int TIW   = $clog2(TILES);
  localparam int COL_W = 3 * SW;
  localparam int PAD_W = 128 - 4 * COL_W;

  typedef enum logic [1:0] {S_DROP, S_FILL, S_DRAIN} state_t;

  state_t           state;
  logic [1:0]       sub, row;
  logic [TIW-1:0]   tcol, rd;
  logic [TIW:0]     wt;
  logic             have_w;
  logic [SW-1:0]    asm0, asm1;
  logic [COL_W-1:0] rows_rd [4];

  logic           acc, start, live, partial, c_first;
  logic [1:0]     c_sub, c_row;
  logic [TIW-1:0] c_tcol;
  logic           last_s, grp_end, at_w, cap, eol_ok, run_bad, bad, wr;

  assign in_ready  = (state != S_DRAIN);
  assign out_valid = (state == S_DRAIN);
  assign acc       = in_valid && in_ready;
  assign start     = acc && in_sof;
  assign live      = acc && (state == S_FILL || in_sof);
  assign partial   = (state == S_FILL) && (row != 2'd0 || tcol != '0 || sub != 2'd0);

  assign c_sub   = start ? 2'd0 : sub;
  assign c_row   = start ? 2'd0 : row;
  assign c_tcol  = start ? '0 : tcol;
  assign c_first = start ? 1'b1 : !have_w;

  assign last_s  = (c_sub == 2'd2);
  assign grp_end = (c_tcol[3:0] == 4'hF);
  assign at_w    = (({1'b0, c_tcol} + 1'b1) == wt);
  assign cap     = (c_tcol == TIW'(TILES - 1));
  assign eol_ok  = last_s && grp_end && (c_first || at_w);
  assign run_bad = last_s && !in_eol && (cap || (!c_first && at_w));
  assign bad     = live && ((in_eol && !eol_ok) || run_bad);
  assign wr      = live && last_s && !bad;

  for (genvar r = 0; r < 4; r++) begin : g_row
    logic [COL_W-1:0] mem [TILES];
    always_ff @(posedge clk) begin
      if (wr && c_row == 2'(r)) mem[c_tcol] <= {in_data, asm1, asm0};
    end
    assign rows_rd[r] = mem[rd];
  end

  assign out_data   = {{PAD_W{1'b0}}, rows_rd[3], rows_rd[2], rows_rd[1], rows_rd[0]};
  assign out_tile   = rd;
  assign out_gstart = (rd[3:0] == 4'h0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_DROP;
      sub    <= '0;
      row    <= '0;
      tcol   <= '0;
      rd     <= '0;
      wt     <= '0;
      have_w <= 1'b0;
      asm0   <= '0;
      asm1   <= '0;
      err    <= 1'b0;
    end else begin
      if (start) begin
        err    <= partial;
        have_w <= 1'b0;
      end
      if (live) begin
        if (c_sub == 2'd0) asm0 <= in_data;
        if (c_sub == 2'd1) asm1 <= in_data;
        if (bad) begin
          err   <= 1'b1;
          state <= S_DROP;
        end else if (in_eol) begin
          sub  <= '0;
          tcol <= '0;
          if (c_first) begin
            wt     <= {1'b0, c_tcol} + 1'b1;
            have_w <= 1'b1;
          end
          if (c_row == 2'd3) begin
            row   <= '0;
            rd    <= '0;
            state <= S_DRAIN;
          end else begin
            row   <= c_row + 2'd1;
            state <= S_FILL;
          end
        end else if (last_s) begin
          sub   <= '0;
          tcol  <= c_tcol + 1'b1;
          row   <= c_row;
          state <= S_FILL;
        end else begin
          sub   <= c_sub + 2'd1;
          tcol  <= c_tcol;
          row   <= c_row;
          state <= S_FILL;
        end
      end
      if (state == S_DRAIN && out_ready) begin
        rd <= rd + 1'b1;
        if (({1'b0, rd} + 1'b1) == wt) state <= S_FILL;
      end
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_tile));

  assert_order_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> !out_valid || out_tile == TIW'($past(out_tile) + 1'b1));

  assert_range_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({1'b0, out_tile} < wt));

  assert_first_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_tile == '0 && have_w);

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !out_valid);
endmodule

// File: tb/raster_tile_packer_bench.sv
module raster_tile_packer_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [9:0]   in_data = '0;
  logic         out_ready = 1'b0;
  logic         in_ready, out_valid, out_gstart, err;
  logic [127:0] out_data;
  logic [9:0]   out_tile;
  int           nchk = 0, nfail = 0;
  bit           done = 0;

  raster_tile_packer u_raster_tile_packer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_tile(out_tile), .out_gstart(out_gstart), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] pix(int seed, int r, int c);
    int v;
    v = seed * 131 + r * 61 + c * 7 + r * c;
    return v[9:0];
  endfunction

  function automatic logic [127:0] exp_tile(int seed, int trow, int t);
    logic [127:0] w;
    w = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 3; c++)
        w[10*(3*r+c) +: 10] = pix(seed, trow*4 + r, t*3 + c);
    return w;
  endfunction

  task automatic push(logic [9:0] d, bit s, bit e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eol = e;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic push_line(int seed, int row, int width, bit sof);
    for (int c = 0; c < width; c++)
      push(pix(seed, row, c), sof && c == 0, c == width - 1);
  endtask

  task automatic collect(int seed, int trow, int wt, bit stall);
    logic [127:0] held;
    bit hold;
    int i, cyc;
    hold = 0; i = 0; cyc = 0;
    @(negedge clk);
    while (i < wt && cyc < 5000) begin
      if (hold) check(out_valid && out_data == held, "R5 held tile", out_data, held);
      hold = 0;
      out_ready = stall ? (cyc % 3 == 2) : 1'b1;
      if (out_valid) begin
        check(!in_ready, "R6 input stalled", 128'(in_ready), 128'(0));
        if (out_ready) begin
          check(out_data == exp_tile(seed, trow, i), "R2 tile data", out_data, exp_tile(seed, trow, i));
          check(out_tile == 10'(i), "R3 tile index", 128'(out_tile), 128'(i));
          check(out_gstart == (i % 16 == 0), "R4 group start", 128'(out_gstart), 128'(i % 16 == 0));
          i++;
        end else begin
          held = out_data;
          hold = 1;
        end
      end
      cyc++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(i == wt, "R3 tile count", 128'(i), 128'(wt));
    check(in_ready && !out_valid, "R6 ready after band", 128'({in_ready, out_valid}), 128'(2'b10));
  endtask

  task automatic band(int seed, int trow, int width, bit sof, bit stall);
    for (int r = 0; r < 3; r++) push_line(seed, trow*4 + r, width, sof && r == 0);
    @(negedge clk);
    check(!out_valid, "R3 no tile before fourth line", 128'(out_valid), 128'(0));
    push_line(seed, trow*4 + 3, width, 1'b0);
    @(negedge clk);
    check(out_valid, "R3 tiles after fourth line", 128'(out_valid), 128'(1));
    collect(seed, trow, width / 3, stall);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(in_ready && !out_valid && !err, "R1 reset state",
          128'({in_ready, out_valid, err}), 128'(3'b100));
  endtask

  task automatic t_basic();
    for (int c = 0; c < 5; c++) push(10'(c), 1'b0, c == 4);
    @(negedge clk);
    check(!out_valid && in_ready, "R9 pre-frame samples ignored", 128'({out_valid, in_ready}), 128'(2'b01));
    band(3, 0, 96, 1'b1, 1'b0);
  endtask

  task automatic t_backpressure();
    band(7, 0, 48, 1'b1, 1'b1);
    band(7, 1, 48, 1'b0, 1'b1);
    check(!err, "R10 two bands no error", 128'(err), 128'(0));
  endtask

  task automatic t_bad_width();
    push_line(11, 0, 50, 1'b1);
    @(negedge clk);
    check(err, "R7 width not multiple of 48", 128'(err), 128'(1));
    for (int r = 1; r < 4; r++) push_line(11, r, 48, 1'b0);
    @(negedge clk);
    check(!out_valid && in_ready, "R7 frame dropped", 128'({out_valid, in_ready}), 128'(2'b01));
  endtask

  task automatic t_recover(int seed);
    push(pix(seed, 0, 0), 1'b1, 1'b0);
    @(negedge clk);
    check(!err, "R9 err cleared by sof", 128'(err), 128'(0));
    for (int c = 1; c < 48; c++) push(pix(seed, 0, c), 1'b0, c == 47);
    for (int r = 1; r < 3; r++) push_line(seed, r, 48, 1'b0);
    push_line(seed, 3, 48, 1'b0);
    @(negedge clk);
    collect(seed, 0, 16, 1'b0);
  endtask

  task automatic t_mismatch();
    push_line(13, 0, 96, 1'b1);
    push_line(13, 1, 48, 1'b0);
    @(negedge clk);
    check(err, "R7 width changes between lines", 128'(err), 128'(1));
    check(!out_valid, "R7 no tile after width error", 128'(out_valid), 128'(0));
  endtask

  task automatic t_short();
    push_line(17, 0, 48, 1'b1);
    push_line(17, 1, 48, 1'b0);
    @(negedge clk);
    check(!err, "R8 no error mid-band", 128'(err), 128'(0));
    push_line(19, 0, 48, 1'b1);
    @(negedge clk);
    check(err, "R8 short frame flagged", 128'(err), 128'(1));
    for (int r = 1; r < 4; r++) push_line(19, r, 48, 1'b0);
    @(negedge clk);
    collect(19, 0, 16, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_basic();
    t_backpressure();
    t_bad_width();
    t_recover(23);
    t_mismatch();
    t_short();
    t_recover(29);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule